// File: doc/BRIEF.md
# DRAM Controller Bring-Up Register Stub

This block is a small word-addressed register window that answers boot firmware as though a DRAM controller were present and fully working. Firmware writes a start request for memory initialisation or data training into the control register. It then polls until the request bit reads back as zero. Firmware also writes the impedance calibration control register and waits for a done flag in the calibration status register. The stub finishes every such request in the same write: request bits are never stored, and the done flag is set by the write itself. Firmware therefore runs through its bring-up sequence without waiting.

Access uses a plain 32-bit register bus with an address, a write strobe with data, and a read strobe. Read data comes back one cycle after the read strobe. Two one-cycle indication pulses report accesses that fall outside the live registers. One pulse covers holes inside the implemented range. The other covers the out-of-bounds tail of the window. Only aligned word accesses reach a live register.

Top module: `dram_init_stub`

## Requirements
- R1: A synchronous active-high reset loads the control register (offset 0x000) with 0x80020000, the calibration control register (offset 0x0A8) with 0x07B00000, and the calibration status register (offset 0x0B0) with 0x80000000 in one cycle, and clears rd_data and both indication outputs.
- R2: A write to the control register stores the written word with bit 31 (init request) and bit 30 (training request) forced to zero, and every other bit as written.
- R3: A write to the calibration control register stores the written word and sets bit 31 (calibration done) of the calibration status register, leaving that register's bits 30..0 unchanged.
- R4: A write to the calibration status register replaces its contents with the written word and changes neither of the other two registers.
- R5: rd_data presents the addressed register on the cycle after a cycle with rd_en high, and keeps its value through cycles without rd_en.
- R6: A read of any offset other than the three live registers returns zero, and a write there changes no live register.
- R7: An access (read or write) at a byte offset from 0x2E4 up to the top of the window raises err_oob for exactly the following cycle, with err_unimpl low.
- R8: An access to a non-live offset below 0x2E4 raises err_unimpl for exactly the following cycle, with err_oob low; an access to a live register raises neither.
- R9: An address whose two low bits are not zero is never a live register: it reads as zero, its write is dropped, and it counts as an unimplemented access when below 0x2E4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 12 | Byte address within the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| err_oob | output | 1 | One-cycle pulse after an access in the out-of-bounds tail |
| err_unimpl | output | 1 | One-cycle pulse after an access to an unimplemented offset |

## Verification
The bench builds the block with its default parameters: a 12-bit address giving a 4 KiB window, the out-of-bounds tail starting at 0x2E4, and strict alignment enabled. With these values both sides of the hole/tail boundary (0x2E0 and 0x2E4) and the last word of the window (0xFFC) are reachable. Misaligned aliases of the live registers are also reachable, so the bench can confirm they never touch stored state. Because the reset values and the request and done bit positions are parameters, the bench also confirms that their defaults give the expected readback and auto-completion patterns.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

   localparam int unsigned DATA_W = 32;

   // one-hot classification of the current bus address
   typedef struct packed {
      logic hit_ctrl;
      logic hit_zqc;
      logic hit_zqs;
      logic hole;
      logic tail;
   } dcs_sel_t;

endpackage

// File: rtl/dcs_decode.sv
module dcs_decode #(
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned CTRL_OFS     = 'h000,
   parameter int unsigned ZQC_OFS      = 'h0A8,
   parameter int unsigned ZQS_OFS      = 'h0B0,
   parameter int unsigned TAIL_START   = 'h2E4,
   parameter bit          STRICT_ALIGN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output dcs_pkg::dcs_sel_t sel
);
   localparam int unsigned IDX_W    = ADDR_W - 2;
   localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(CTRL_OFS / 4);
   localparam logic [IDX_W-1:0] ZQC_IDX  = IDX_W'(ZQC_OFS / 4);
   localparam logic [IDX_W-1:0] ZQS_IDX  = IDX_W'(ZQS_OFS / 4);
   localparam logic [ADDR_W-1:0] TAIL_A  = ADDR_W'(TAIL_START);

   logic [IDX_W-1:0] word_idx;
   logic             aligned;
   logic             in_tail;
   logic             live_any;

   assign word_idx = addr[ADDR_W-1:2];

   generate
      if (STRICT_ALIGN) begin : g_strict
         assign aligned = (addr[1:0] == 2'b00);
      end else begin : g_loose
         assign aligned = 1'b1;
      end
   endgenerate

   assign in_tail = (addr >= TAIL_A);

   always_comb begin
      sel          = '0;
      sel.tail     = in_tail;
      sel.hit_ctrl = !in_tail && aligned && (word_idx == CTRL_IDX);
      sel.hit_zqc  = !in_tail && aligned && (word_idx == ZQC_IDX);
      sel.hit_zqs  = !in_tail && aligned && (word_idx == ZQS_IDX);
      live_any     = sel.hit_ctrl || sel.hit_zqc || sel.hit_zqs;
      sel.hole     = !in_tail && !live_any;
   end

endmodule

// File: rtl/dcs_regs.sv
module dcs_regs #(
   parameter int unsigned       DW        = 32,
   parameter logic [DW-1:0]     CTRL_RST  = 32'h8002_0000,
   parameter logic [DW-1:0]     ZQC_RST   = 32'h07B0_0000,
   parameter logic [DW-1:0]     ZQS_RST   = 32'h8000_0000,
   parameter int unsigned       INIT_BIT  = 31,
   parameter int unsigned       TRAIN_BIT = 30,
   parameter int unsigned       DONE_BIT  = 31
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DW-1:0]     wr_data,
   input  dcs_pkg::dcs_sel_t sel,
   output logic [DW-1:0]     ctrl_q,
   output logic [DW-1:0]     zqc_q,
   output logic [DW-1:0]     zqs_q
);
   localparam logic [DW-1:0] REQ_MASK  = (DW'(1) << INIT_BIT) | (DW'(1) << TRAIN_BIT);
   localparam logic [DW-1:0] DONE_MASK = DW'(1) << DONE_BIT;

   generate
      if (INIT_BIT >= DW || TRAIN_BIT >= DW || DONE_BIT >= DW) begin : g_bad_bit
         $error("dcs_regs: request or done bit outside the data width");
      end
      if (INIT_BIT == TRAIN_BIT) begin : g_same_bit
         $error("dcs_regs: init and training requests share one bit");
      end
   endgenerate

   // control register: requests complete at once, so they are never stored
   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= CTRL_RST;
      end else if (wr_en && sel.hit_ctrl) begin
         ctrl_q <= wr_data & ~REQ_MASK;
      end
   end

   // calibration control register: plain storage
   always_ff @(posedge clk) begin
      if (rst) begin
         zqc_q <= ZQC_RST;
      end else if (wr_en && sel.hit_zqc) begin
         zqc_q <= wr_data;
      end
   end

   // calibration status: direct overwrite, or done flag raised by a calibration start
   always_ff @(posedge clk) begin
      if (rst) begin
         zqs_q <= ZQS_RST;
      end else if (wr_en && sel.hit_zqs) begin
         zqs_q <= wr_data;
      end else if (wr_en && sel.hit_zqc) begin
         zqs_q <= zqs_q | DONE_MASK;
      end
   end

   assert_reset_ctrl_R1: assert property (@(posedge clk)
      rst |=> (ctrl_q == CTRL_RST && zqc_q == ZQC_RST && zqs_q == ZQS_RST))
      else $error("R1: reset values not loaded");

   assert_req_cleared_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && sel.hit_ctrl) |=> ((ctrl_q & REQ_MASK) == '0))
      else $error("R2: request bit stored");

   assert_done_set_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && sel.hit_zqc) |=> ((zqs_q & DONE_MASK) != '0))
      else $error("R3: calibration done not set");

   assert_low_bits_kept_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && sel.hit_zqc) |=> ((zqs_q & ~DONE_MASK) == ($past(zqs_q) & ~DONE_MASK)))
      else $error("R3: status low bits disturbed");

   assert_others_stable_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && sel.hit_zqs) |=> ($stable(ctrl_q) && $stable(zqc_q)))
      else $error("R4: status write disturbed another register");

   assert_nonlive_write_R6: assert property (@(posedge clk) disable iff (rst)
      (!(wr_en && (sel.hit_ctrl || sel.hit_zqc || sel.hit_zqs)))
         |=> ($stable(ctrl_q) && $stable(zqc_q) && $stable(zqs_q)))
      else $error("R6: register changed without a live write");

endmodule

// File: rtl/dcs_rdport.sv
module dcs_rdport #(
   parameter int unsigned DW = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic              wr_en,
   input  dcs_pkg::dcs_sel_t sel,
   input  logic [DW-1:0]     ctrl_q,
   input  logic [DW-1:0]     zqc_q,
   input  logic [DW-1:0]     zqs_q,
   output logic [DW-1:0]     rd_data,
   output logic              err_oob,
   output logic              err_unimpl
);
   logic [DW-1:0] rd_mux;
   logic          access;

   assign access = rd_en || wr_en;

   always_comb begin
      rd_mux = '0;
      if (sel.hit_ctrl) rd_mux = ctrl_q;
      if (sel.hit_zqc)  rd_mux = zqc_q;
      if (sel.hit_zqs)  rd_mux = zqs_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= rd_mux;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         err_oob    <= 1'b0;
         err_unimpl <= 1'b0;
      end else begin
         err_oob    <= access && sel.tail;
         err_unimpl <= access && sel.hole;
      end
   end

   assert_rd_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rd_data))
      else $error("R5: read data changed without a read");

   assert_flags_apart_R8: assert property (@(posedge clk) disable iff (rst)
      !(err_oob && err_unimpl))
      else $error("R8: both indications raised");

   assert_tail_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      (access && sel.tail) |=> (err_oob && !err_unimpl))
      else $error("R7: tail access not flagged");

endmodule

// File: rtl/dram_init_stub.sv
module dram_init_stub #(
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned CTRL_OFS     = 'h000,
   parameter int unsigned ZQC_OFS      = 'h0A8,
   parameter int unsigned ZQS_OFS      = 'h0B0,
   parameter int unsigned TAIL_START   = 'h2E4,
   parameter bit          STRICT_ALIGN = 1'b1,
   parameter logic [31:0] CTRL_RST     = 32'h8002_0000,
   parameter logic [31:0] ZQC_RST      = 32'h07B0_0000,
   parameter logic [31:0] ZQS_RST      = 32'h8000_0000,
   parameter int unsigned INIT_BIT     = 31,
   parameter int unsigned TRAIN_BIT    = 30,
   parameter int unsigned DONE_BIT     = 31
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   input  logic              rd_en,
   output logic [31:0]       rd_data,
   output logic              err_oob,
   output logic              err_unimpl
);
   localparam int unsigned DW       = dcs_pkg::DATA_W;
   localparam int unsigned WIN_SIZE = 1 << ADDR_W;

   generate
      if (ADDR_W < 3) begin : g_bad_width
         $error("dram_init_stub: address too narrow");
      end
      if ((CTRL_OFS % 4) != 0 || (ZQC_OFS % 4) != 0 || (ZQS_OFS % 4) != 0) begin : g_bad_align
         $error("dram_init_stub: live offsets must be word aligned");
      end
      if (CTRL_OFS >= TAIL_START || ZQC_OFS >= TAIL_START || ZQS_OFS >= TAIL_START) begin : g_bad_live
         $error("dram_init_stub: live offset inside the out-of-bounds tail");
      end
      if (TAIL_START > WIN_SIZE) begin : g_bad_tail
         $error("dram_init_stub: tail start beyond the window");
      end
      if (CTRL_OFS == ZQC_OFS || CTRL_OFS == ZQS_OFS || ZQC_OFS == ZQS_OFS) begin : g_bad_overlap
         $error("dram_init_stub: live offsets overlap");
      end
   endgenerate

   dcs_pkg::dcs_sel_t sel;
   logic [DW-1:0]     ctrl_q;
   logic [DW-1:0]     zqc_q;
   logic [DW-1:0]     zqs_q;

   dcs_decode #(
      .ADDR_W      (ADDR_W),
      .CTRL_OFS    (CTRL_OFS),
      .ZQC_OFS     (ZQC_OFS),
      .ZQS_OFS     (ZQS_OFS),
      .TAIL_START  (TAIL_START),
      .STRICT_ALIGN(STRICT_ALIGN)
   ) u_decode (
      .addr(addr),
      .sel (sel)
   );

   dcs_regs #(
      .DW       (DW),
      .CTRL_RST (CTRL_RST),
      .ZQC_RST  (ZQC_RST),
      .ZQS_RST  (ZQS_RST),
      .INIT_BIT (INIT_BIT),
      .TRAIN_BIT(TRAIN_BIT),
      .DONE_BIT (DONE_BIT)
   ) u_regs (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .sel    (sel),
      .ctrl_q (ctrl_q),
      .zqc_q  (zqc_q),
      .zqs_q  (zqs_q)
   );

   dcs_rdport #(
      .DW(DW)
   ) u_rdport (
      .clk       (clk),
      .rst       (rst),
      .rd_en     (rd_en),
      .wr_en     (wr_en),
      .sel       (sel),
      .ctrl_q    (ctrl_q),
      .zqc_q     (zqc_q),
      .zqs_q     (zqs_q),
      .rd_data   (rd_data),
      .err_oob   (err_oob),
      .err_unimpl(err_unimpl)
   );

   assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot({sel.hit_ctrl, sel.hit_zqc, sel.hit_zqs, sel.hole, sel.tail}))
      else $error("R8: address classification not one-hot");

   assert_misaligned_R9: assert property (@(posedge clk) disable iff (rst)
      (STRICT_ALIGN && (addr[1:0] != 2'b00) && (rd_en || wr_en) && !sel.tail) |=> err_unimpl)
      else $error("R9: misaligned access not flagged");

   assert_zero_read_R6: assert property (@(posedge clk) disable iff (rst)
      (rd_en && (sel.hole || sel.tail)) |=> (rd_data == '0))
      else $error("R6: non-live read returned data");

endmodule

// File: tb/dram_init_stub_tb_top.sv
module dram_init_stub_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        err_oob;
   logic        err_unimpl;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_init_stub dut_i (
      .clk       (clk),
      .rst       (rst),
      .addr      (addr),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_en     (rd_en),
      .rd_data   (rd_data),
      .err_oob   (err_oob),
      .err_unimpl(err_unimpl)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // one bus cycle: drive on the falling edge, let the rising edge capture,
   // release on the next falling edge where the registered results are visible
   task automatic bus(input bit wr, input bit rd, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_en = wr; rd_en = rd; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      bus(1'b0, 1'b1, a, 32'h0);
      check(req, rd_data, exp);
   endtask

   task automatic t_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      check("R1 rd_data", rd_data, 32'h0);
      check("R1 err_oob", {31'b0, err_oob}, 32'h0);
      check("R1 err_unimpl", {31'b0, err_unimpl}, 32'h0);
      rd_chk("R1 ctrl", 12'h000, 32'h8002_0000);
      rd_chk("R1 zqc", 12'h0A8, 32'h07B0_0000);
      rd_chk("R1 zqs", 12'h0B0, 32'h8000_0000);
      check("R8 live no flag", {30'b0, err_oob, err_unimpl}, 32'h0);
   endtask

   task automatic t_ctrl();
      bus(1'b1, 1'b0, 12'h000, 32'hC000_1234);
      check("R8 live write no flag", {30'b0, err_oob, err_unimpl}, 32'h0);
      rd_chk("R2 both requests", 12'h000, 32'h0000_1234);
      bus(1'b1, 1'b0, 12'h000, 32'h8FFF_0000);
      rd_chk("R2 init only", 12'h000, 32'h0FFF_0000);
      bus(1'b1, 1'b0, 12'h000, 32'h4000_0001);
      rd_chk("R2 training only", 12'h000, 32'h0000_0001);
      bus(1'b1, 1'b0, 12'h000, 32'h3FFF_FFFF);
      rd_chk("R2 no request", 12'h000, 32'h3FFF_FFFF);
   endtask

   task automatic t_status();
      bus(1'b1, 1'b0, 12'h0B0, 32'h0000_00AA);
      rd_chk("R4 status overwrite", 12'h0B0, 32'h0000_00AA);
      rd_chk("R4 ctrl untouched", 12'h000, 32'h3FFF_FFFF);
      rd_chk("R4 zqc untouched", 12'h0A8, 32'h07B0_0000);
   endtask

   task automatic t_calib();
      bus(1'b1, 1'b0, 12'h0A8, 32'h1234_5678);
      rd_chk("R3 zqc stored", 12'h0A8, 32'h1234_5678);
      rd_chk("R3 done set", 12'h0B0, 32'h8000_00AA);
      bus(1'b1, 1'b0, 12'h0A8, 32'h0000_0000);
      rd_chk("R3 done stays", 12'h0B0, 32'h8000_00AA);
      rd_chk("R3 zqc zero", 12'h0A8, 32'h0000_0000);
   endtask

   task automatic t_hole();
      bus(1'b1, 1'b0, 12'h004, 32'hFFFF_FFFF);
      check("R8 hole write flag", {30'b0, err_oob, err_unimpl}, 32'h1);
      @(negedge clk);
      check("R8 pulse ends", {30'b0, err_oob, err_unimpl}, 32'h0);
      rd_chk("R6 hole reads zero", 12'h004, 32'h0);
      check("R8 hole read flag", {30'b0, err_oob, err_unimpl}, 32'h1);
      bus(1'b1, 1'b0, 12'h2E0, 32'hFFFF_FFFF);
      check("R8 last hole word", {30'b0, err_oob, err_unimpl}, 32'h1);
      rd_chk("R6 ctrl unchanged", 12'h000, 32'h3FFF_FFFF);
      rd_chk("R6 zqs unchanged", 12'h0B0, 32'h8000_00AA);
   endtask

   task automatic t_tail();
      rd_chk("R6 tail reads zero", 12'h2E4, 32'h0);
      check("R7 tail start flag", {30'b0, err_oob, err_unimpl}, 32'h2);
      bus(1'b1, 1'b0, 12'hFFC, 32'hFFFF_FFFF);
      check("R7 window top flag", {30'b0, err_oob, err_unimpl}, 32'h2);
      @(negedge clk);
      check("R7 pulse ends", {30'b0, err_oob, err_unimpl}, 32'h0);
      rd_chk("R6 zqc unchanged by tail", 12'h0A8, 32'h0000_0000);
   endtask

   task automatic t_misaligned();
      bus(1'b1, 1'b0, 12'h0A9, 32'hDEAD_BEEF);
      check("R9 misaligned flag", {30'b0, err_oob, err_unimpl}, 32'h1);
      rd_chk("R9 zqc kept", 12'h0A8, 32'h0000_0000);
      rd_chk("R9 misaligned read zero", 12'h001, 32'h0);
      bus(1'b1, 1'b0, 12'h002, 32'h0000_0055);
      rd_chk("R9 ctrl kept", 12'h000, 32'h3FFF_FFFF);
   endtask

   task automatic t_hold();
      rd_chk("R5 read value", 12'h0B0, 32'h8000_00AA);
      @(negedge clk); addr = 12'h000;
      @(negedge clk);
      check("R5 held without read", rd_data, 32'h8000_00AA);
      bus(1'b1, 1'b0, 12'h000, 32'h0000_0077);
      check("R5 held across write", rd_data, 32'h8000_00AA);
      rd_chk("R5 next read", 12'h000, 32'h0000_0077);
   endtask

   task automatic t_reset_again();
      t_reset();
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_ctrl();
      t_status();
      t_calib();
      t_hole();
      t_tail();
      t_misaligned();
      t_hold();
      t_reset_again();
      done = 1'b1;
      finish_run();
   end

endmodule